// File: doc/BRIEF.md
# Serial ADC Interface Slave Model

This block models the pin-level digital serial port of an 8-bit sampling converter. A host drives an active-low chip-select and a serial clock; the block answers on a serial data line with a separate output-enable standing in for the tri-state driver. The conversion result is not produced here: the sample value to be reported is presented on a parallel input and captured when a frame opens. All pins are sampled in a faster system-clock domain, and edges on chip-select and the serial clock are found by comparing each sample with the previous one.

Each frame carries sixteen bit slots. The first is driven as chip-select falls, and one more follows on each serial-clock falling edge. Four zero slots come first, then the captured sample most significant bit first, then four zero slots. Where chip-select rises within the frame decides what comes next. A frame that gets past the acquisition point leaves a valid sample for the following frame. An early rise in the middle window puts the device into power-down. A rise at any other early point only aborts the frame. After a power-down, one full frame is needed to wake the device, and that frame reports zeros. A registered flag and a two-bit phase output give this status to the host model.

Top module: `adc_serial_port`

## Requirements
- R1: During and after reset, sdo_oe, sdo and data_valid are 0 and phase is 0 (idle). The first frame after reset carries no valid sample.
- R2: One system clock after chip-select is seen falling, sdo_oe is 1, sdo is 0 and phase is 1 (converting). The sample input is captured at that point, and later changes to it during the frame have no effect on the frame's data.
- R3: Slot 0 is driven at the chip-select fall and slot n after serial-clock falling edge n (n = 1..15). Slots 0-3 and 12-15 are 0. Slot 4+k carries captured bit 7-k when the frame is valid, and 0 otherwise.
- R4: On the 16th falling edge sdo_oe drops to 0. Further serial-clock edges while chip-select stays low leave it at 0.
- R5: One system clock after chip-select is seen rising, sdo_oe and sdo are 0.
- R6: The first serial-clock rising edge after the 11th falling edge starts acquisition: phase becomes 2. A frame that reaches this point makes the next frame valid, whether it ends after 12 clocks or after 16.
- R7: If chip-select rises after 2 to 9 falling edges and before acquisition, phase becomes 3 (power-down) and the next frame is invalid.
- R8: If chip-select rises after 0, 1, 10 or 11 falling edges and before acquisition, the frame is aborted and the next frame is invalid. Phase becomes 0, or stays 3 if the device was powered down.
- R9: A frame that starts in power-down reports data_valid 0 and drives zero data. If it reaches acquisition, the power-down ends and the next frame is valid.
- R10: data_valid states whether the current or coming frame carries a real sample. It changes only one clock after a chip-select rise, it is 0 while phase is 3, and sdo is never 1 unless data_valid is 1.
- R11: Serial-clock edges while chip-select is high are ignored: outputs and phase stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select from the host |
| sclk | input | 1 | Serial clock from the host, sampled on clk |
| sample | input | DATA_W | Conversion result captured at frame start |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| data_valid | output | 1 | Current or next frame carries a real sample |
| phase | output | 2 | 0 idle, 1 converting, 2 acquiring, 3 power-down |

## Verification
A wrong edge count shows as a shifted data word on sdo within the same frame, or as sdo_oe dropping on the wrong falling edge. A wrong power-down or acquisition record cannot be seen on sdo until the next frame. It does show on phase one clock after the chip-select rise, and on data_valid in the frame after that. For this reason the bench runs frames back to back and carries state across them: every early-termination point is followed by a full frame that checks the validity it inherited.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DATA_W   = 8,
  parameter int PAD      = 4,
  parameter int PD_FIRST = 2,
  parameter int PD_LAST  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              data_valid,
  output logic [1:0]        phase
);
  localparam int FRAME = DATA_W + 2 * PAD;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int IW    = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  localparam logic [CW-1:0] LAST_EDGE = CW'(FRAME);
  localparam logic [CW-1:0] ACQ_AT    = CW'(PAD + DATA_W - 1);
  localparam logic [CW-1:0] DATA_LO   = CW'(PAD);
  localparam logic [CW-1:0] DATA_HI   = CW'(PAD + DATA_W);
  localparam logic [CW-1:0] PD_LO     = CW'(PD_FIRST);
  localparam logic [CW-1:0] PD_HI     = CW'(PD_LAST);

  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_CONV = 2'd1;
  localparam logic [1:0] PH_ACQ  = 2'd2;
  localparam logic [1:0] PH_PD   = 2'd3;

  logic              cs_d, sclk_d;
  logic              in_frame, acq_hit, pd;
  logic [CW-1:0]     fcnt, nxt;
  logic [DATA_W-1:0] lat;
  logic [IW-1:0]     idx;
  logic              cs_fall, cs_rise, sclk_fall, sclk_rise, in_data;

  assign cs_fall   = cs_d & ~cs_n;
  assign cs_rise   = ~cs_d & cs_n;
  assign sclk_fall = sclk_d & ~sclk;
  assign sclk_rise = ~sclk_d & sclk;
  assign nxt       = fcnt + 1'b1;
  assign idx       = IW'(ACQ_AT - nxt);
  assign in_data   = (nxt >= DATA_LO) && (nxt < DATA_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d       <= 1'b1;
      sclk_d     <= 1'b0;
      in_frame   <= 1'b0;
      acq_hit    <= 1'b0;
      pd         <= 1'b0;
      fcnt       <= '0;
      lat        <= '0;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b0;
      data_valid <= 1'b0;
      phase      <= PH_IDLE;
    end else begin
      cs_d   <= cs_n;
      sclk_d <= sclk;
      if (cs_fall) begin
        in_frame <= 1'b1;
        acq_hit  <= 1'b0;
        fcnt     <= '0;
        lat      <= sample;
        sdo      <= 1'b0;
        sdo_oe   <= 1'b1;
        phase    <= PH_CONV;
      end else if (cs_rise && in_frame) begin
        in_frame <= 1'b0;
        sdo      <= 1'b0;
        sdo_oe   <= 1'b0;
        if (acq_hit) begin
          data_valid <= 1'b1;
        end else if (fcnt >= PD_LO && fcnt <= PD_HI) begin
          data_valid <= 1'b0;
          pd         <= 1'b1;
          phase      <= PH_PD;
        end else begin
          data_valid <= 1'b0;
          phase      <= pd ? PH_PD : PH_IDLE;
        end
      end else if (in_frame) begin
        if (sclk_rise && fcnt == ACQ_AT && !acq_hit) begin
          acq_hit <= 1'b1;
          pd      <= 1'b0;
          phase   <= PH_ACQ;
        end
        if (sclk_fall && fcnt != LAST_EDGE) begin
          fcnt <= nxt;
          if (nxt == LAST_EDGE) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
          end else begin
            sdo <= in_data & data_valid & lat[idx];
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       data_valid,
  input logic [1:0] phase
);
  assert_frame_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> (sdo_oe && !sdo));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> (!sdo_oe && !sdo));

  assert_pd_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |-> !data_valid);

  assert_sdo_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sdo |-> (sdo_oe && data_valid));

  assert_valid_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_valid) |-> ($past(cs_n, 1) && !$past(cs_n, 2)));
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo),
  .sdo_oe(sdo_oe), .data_valid(data_valid), .phase(phase)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic [7:0] sample = 8'h00;
  logic       sdo, sdo_oe, data_valid;
  logic [1:0] phase;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  adc_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
    .sdo(sdo), .sdo_oe(sdo_oe), .data_valid(data_valid), .phase(phase)
  );

  // {sample, falling edges, extra rise, expected valid, expected phase after}
  localparam logic [16:0] VEC [16] = '{
    {8'hA5, 5'd16, 1'b0, 1'b0, 2'd2},
    {8'h3C, 5'd16, 1'b0, 1'b1, 2'd2},
    {8'hFF, 5'd12, 1'b0, 1'b1, 2'd2},
    {8'h81, 5'd11, 1'b1, 1'b1, 2'd2},
    {8'h55, 5'd11, 1'b0, 1'b1, 2'd0},
    {8'h99, 5'd16, 1'b0, 1'b0, 2'd2},
    {8'h12, 5'd5,  1'b0, 1'b1, 2'd3},
    {8'h34, 5'd16, 1'b0, 1'b0, 2'd2},
    {8'h56, 5'd16, 1'b0, 1'b1, 2'd2},
    {8'h77, 5'd1,  1'b0, 1'b1, 2'd0},
    {8'h88, 5'd2,  1'b0, 1'b0, 2'd3},
    {8'h9A, 5'd9,  1'b0, 1'b0, 2'd3},
    {8'hBC, 5'd10, 1'b0, 1'b0, 2'd3},
    {8'hDE, 5'd16, 1'b0, 1'b0, 2'd2},
    {8'hF0, 5'd16, 1'b0, 1'b1, 2'd2},
    {8'h0F, 5'd20, 1'b0, 1'b1, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] v, input int nfe, input bit extra,
                           input bit ev, input logic [1:0] eph);
    logic [15:0] got, exp, mask;
    bit oe_ok, oe_off;
    got = '0; mask = '0; oe_ok = 1'b1; oe_off = 1'b1;
    exp = ev ? {4'b0, v, 4'b0} : 16'h0;
    @(negedge clk); cs_n = 1'b0; sample = v;
    @(negedge clk); sample = ~v;
    @(negedge clk);
    got[15] = sdo; mask[15] = 1'b1;
    if (!sdo_oe) oe_ok = 1'b0;
    chk(phase == 2'd1, "R2 phase at frame open", 32'(phase), 32'd1);
    chk(data_valid == ev, "R10 data_valid of frame", 32'(data_valid), 32'(ev));
    for (int n = 1; n <= nfe; n++) begin
      sclk = 1'b1; wait_n(3);
      sclk = 1'b0; wait_n(2);
      if (n < 16) begin
        got[15-n] = sdo; mask[15-n] = 1'b1;
        if (!sdo_oe) oe_ok = 1'b0;
      end else if (sdo_oe || sdo) oe_off = 1'b0;
      wait_n(1);
    end
    if (extra) begin sclk = 1'b1; wait_n(3); end
    chk(oe_ok, "R2 output enabled in frame", 32'(oe_ok), 32'd1);
    chk((got & mask) == (exp & mask), "R3 serial word", 32'(got & mask), 32'(exp & mask));
    if (nfe >= 16) chk(oe_off, "R4 tri-state from 16th edge", 32'(oe_off), 32'd1);
    cs_n = 1'b1; wait_n(2);
    chk(!sdo_oe && !sdo, "R5 release on chip-select rise", {30'b0, sdo_oe, sdo}, 32'd0);
    chk(phase == eph, "R6 R7 R8 R9 phase after frame", 32'(phase), 32'(eph));
    sclk = 1'b0; wait_n(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    chk(!sdo_oe && !sdo && !data_valid && phase == 2'd0, "R1 reset state",
        {27'b0, sdo_oe, sdo, data_valid, phase}, 32'd0);
    rst_n = 1'b1;
    wait_n(2);
    chk(!sdo_oe && !data_valid && phase == 2'd0, "R1 after reset release",
        {28'b0, sdo_oe, data_valid, phase}, 32'd0);

    for (int i = 0; i < 16; i++)
      run_frame(VEC[i][16:9], int'(VEC[i][8:4]), VEC[i][3], VEC[i][2], VEC[i][1:0]);

    // R11: serial clock with chip-select high
    for (int k = 0; k < 4; k++) begin
      sclk = 1'b1; wait_n(3);
      sclk = 1'b0; wait_n(3);
    end
    chk(!sdo_oe && !sdo && data_valid && phase == 2'd2, "R11 sclk ignored while deselected",
        {27'b0, sdo_oe, sdo, data_valid, phase}, 32'h6);

    // R9 R10: power down, then a wake frame aborted early stays powered down
    run_frame(8'hC3, 3, 1'b0, 1'b1, 2'd3);
    chk(!data_valid, "R10 invalid after power-down", 32'(data_valid), 32'd0);
    run_frame(8'hC3, 0, 1'b0, 1'b0, 2'd3);
    run_frame(8'h5A, 16, 1'b0, 1'b0, 2'd2);
    run_frame(8'h5A, 16, 1'b0, 1'b1, 2'd2);

    // R1: reset in mid-frame
    @(negedge clk); cs_n = 1'b0;
    wait_n(2);
    sclk = 1'b1; wait_n(3); sclk = 1'b0; wait_n(3);
    rst_n = 1'b0; cs_n = 1'b1;
    wait_n(2);
    chk(!sdo_oe && !sdo && !data_valid && phase == 2'd0, "R1 reset during frame",
        {27'b0, sdo_oe, sdo, data_valid, phase}, 32'd0);
    rst_n = 1'b1;
    wait_n(2);
    run_frame(8'h66, 16, 1'b0, 1'b0, 2'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule